// File: doc/BRIEF.md
# Two-Way Flagged Message Channel

This block joins two agents through a pair of one-message mailboxes. Side A (the lower-numbered agent) fills the upstream mailbox and side B drains it. Side B fills the downstream mailbox and side A drains it. A message is a fixed block of `NUM_WORDS` words of `WORD_W` bits. Each mailbox carries a two-bit status that both sides can see, and the two agents use it as a handshake. The sender claims the mailbox, writes the words, and seals it. The receiver reads the words, marks the message as taken, and then frees the mailbox for the next message.

Each side drives a single command port. The port has an opcode, a mailbox select, a word index and write data. Every command finishes in the cycle it is presented, so the port has no back-pressure and no ready signal. A side may present a new command on every clock. Read data comes back one cycle after a read command and is qualified by a one-cycle valid pulse. That valid is the only flow-control signal on the read side, and there is no stall on it. The block checks each command against the issuing side's role on the selected mailbox and against that mailbox's current status. An illegal command is dropped, and it sets a sticky error flag that belongs to the side that issued it.

Top module: `duplex_mailbox`

## Requirements
- R1: After reset, both status outputs read 0 (idle), both error flags read 0 and both read-valid outputs read 0.
- R2: Status codes are 0 idle, 1 filling, 2 full and 3 taken. Opcode 1 (open) from the sender of a mailbox moves its status from idle or taken to filling on the next clock.
- R3: Opcode 2 (put) from the sender while the status is filling stores the data at the given word index. It does not change the status.
- R4: Opcode 3 (seal) from the sender moves filling to full. A complete send takes six commands: open, four puts and seal. The status first reads full after the sixth.
- R5: Opcode 4 (get) from the receiver while the status is full returns the word at the index on the read data one clock later, with read-valid high for that one clock. Read-valid is low in every other cycle.
- R6: Opcode 5 (done) from the receiver moves full to taken, so a receive takes five commands. Opcode 6 (free) moves taken to idle. If open and free arrive in the same cycle on a taken mailbox, open wins.
- R7: A command issued in a status where it is not allowed changes neither the status nor the stored words, and it sets the issuer's error flag one clock later.
- R8: The select input picks the mailbox: 0 is upstream (A sends, B receives) and 1 is downstream (B sends, A receives). A command whose role does not match the issuer's role on the selected mailbox is rejected in the same way as in R7.
- R9: Opcode 7 is reserved. It is always rejected as in R7, and opcode 0 does nothing.
- R10: The two mailboxes run independently. Both sides may send and receive in the same cycles without affecting each other's data or status.
- R11: An error flag stays set until reset. It is set only by commands from its own side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_op | input | 3 | Side A opcode |
| a_sel | input | 1 | Side A mailbox select |
| a_idx | input | IDX_W | Side A word index |
| a_wdata | input | WORD_W | Side A write data |
| a_rdata | output | WORD_W | Word read by side A from downstream |
| a_rvalid | output | 1 | a_rdata valid pulse |
| a_err | output | 1 | Side A sticky error |
| b_op | input | 3 | Side B opcode |
| b_sel | input | 1 | Side B mailbox select |
| b_idx | input | IDX_W | Side B word index |
| b_wdata | input | WORD_W | Side B write data |
| b_rdata | output | WORD_W | Word read by side B from upstream |
| b_rvalid | output | 1 | b_rdata valid pulse |
| b_err | output | 1 | Side B sticky error |
| up_flag | output | 2 | Upstream mailbox status |
| dn_flag | output | 2 | Downstream mailbox status |

## Verification
The bench builds the block with the default parameters: 64-bit words and four words per message. With four words the index is two bits wide and every index is in range. This keeps the six-command send and five-command receive counts exactly as stated. It also means a put that is dropped shows up as a stale word when the message is read back later. Full-width random words make any crossover between the two mailboxes visible while both sides are streaming in the same cycles.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    FLG_IDLE    = 2'd0,
    FLG_FILLING = 2'd1,
    FLG_FULL    = 2'd2,
    FLG_TAKEN   = 2'd3
  } flag_t;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_OPEN = 3'd1,
    OP_PUT  = 3'd2,
    OP_SEAL = 3'd3,
    OP_GET  = 3'd4,
    OP_DONE = 3'd5,
    OP_FREE = 3'd6,
    OP_RSVD = 3'd7
  } op_t;
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                             clk,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 widx,
  input  logic [WORD_W-1:0]                wdata,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);
  // message storage carries no reset: contents are meaningless until written
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && (widx == IDX_W'(w))) words[w] <= wdata;
    end
  end
endmodule

// File: rtl/mbox_flag_fsm.sv
module mbox_flag_fsm import mbox_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  op_t   snd_op,
  input  logic  snd_idx_ok,
  input  op_t   rcv_op,
  input  logic  rcv_idx_ok,
  output flag_t flag,
  output logic  put_ok,
  output logic  get_ok,
  output logic  snd_bad,
  output logic  rcv_bad
);
  flag_t flag_q, flag_d;
  logic  open_ok, seal_ok, done_ok, free_ok;

  always_comb begin
    open_ok = (snd_op == OP_OPEN) && (flag_q == FLG_IDLE || flag_q == FLG_TAKEN);
    put_ok  = (snd_op == OP_PUT)  && (flag_q == FLG_FILLING) && snd_idx_ok;
    seal_ok = (snd_op == OP_SEAL) && (flag_q == FLG_FILLING);
    get_ok  = (rcv_op == OP_GET)  && (flag_q == FLG_FULL) && rcv_idx_ok;
    done_ok = (rcv_op == OP_DONE) && (flag_q == FLG_FULL);
    free_ok = (rcv_op == OP_FREE) && (flag_q == FLG_TAKEN);
    snd_bad = (snd_op != OP_NOP) && !(open_ok || put_ok || seal_ok);
    rcv_bad = (rcv_op != OP_NOP) && !(get_ok || done_ok || free_ok);
    flag_d  = flag_q;
    if (open_ok)      flag_d = FLG_FILLING;
    else if (seal_ok) flag_d = FLG_FULL;
    else if (done_ok) flag_d = FLG_TAKEN;
    else if (free_ok) flag_d = FLG_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= FLG_IDLE;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R2
  fill_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != FLG_FILLING) ##1 (flag_q == FLG_FILLING)
      |-> ($past(flag_q) == FLG_IDLE || $past(flag_q) == FLG_TAKEN));
  // R4
  full_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != FLG_FULL) ##1 (flag_q == FLG_FULL) |-> $past(flag_q) == FLG_FILLING);
  // R6
  taken_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != FLG_TAKEN) ##1 (flag_q == FLG_TAKEN) |-> $past(flag_q) == FLG_FULL);
endmodule

// File: rtl/mbox_lane.sv
module mbox_lane import mbox_pkg::*; #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_t               snd_op,
  input  logic [IDX_W-1:0]  snd_idx,
  input  logic [WORD_W-1:0] snd_data,
  input  op_t               rcv_op,
  input  logic [IDX_W-1:0]  rcv_idx,
  output flag_t             flag,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              snd_bad,
  output logic              rcv_bad
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  logic put_ok, get_ok, snd_idx_ok, rcv_idx_ok;

  if ((1 << IDX_W) == NUM_WORDS) begin : g_full_range
    assign snd_idx_ok = 1'b1;
    assign rcv_idx_ok = 1'b1;
  end else begin : g_part_range
    assign snd_idx_ok = ({1'b0, snd_idx} < (IDX_W+1)'(NUM_WORDS));
    assign rcv_idx_ok = ({1'b0, rcv_idx} < (IDX_W+1)'(NUM_WORDS));
  end

  mbox_flag_fsm u_fsm (
    .clk, .rst_n, .snd_op, .snd_idx_ok, .rcv_op, .rcv_idx_ok,
    .flag, .put_ok, .get_ok, .snd_bad, .rcv_bad
  );

  mbox_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk, .we(put_ok), .widx(snd_idx), .wdata(snd_data), .words
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= get_ok;
      if (get_ok) rd_data <= words[rcv_idx];
    end
  end

  // R7
  store_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag != FLG_FILLING) |=> $stable(words));
  // R5
  rvalid_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(flag) == FLG_FULL);
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox import mbox_pkg::*; #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        a_op,
  input  logic              a_sel,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic              a_rvalid,
  output logic              a_err,
  input  logic [2:0]        b_op,
  input  logic              b_sel,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic              b_rvalid,
  output logic              b_err,
  output logic [1:0]        up_flag,
  output logic [1:0]        dn_flag
);
  // index 0 = side A / upstream lane, index 1 = side B / downstream lane
  op_t               side_op    [2];
  logic              side_sel   [2];
  logic [IDX_W-1:0]  side_idx   [2];
  logic [WORD_W-1:0] side_wdata [2];
  flag_t             lane_flag  [2];
  logic [WORD_W-1:0] lane_rdata [2];
  logic              lane_rvld  [2];
  logic              lane_sbad  [2];
  logic              lane_rbad  [2];
  logic              err_q      [2];

  assign side_op[0]    = op_t'(a_op);
  assign side_op[1]    = op_t'(b_op);
  assign side_sel[0]   = a_sel;
  assign side_sel[1]   = b_sel;
  assign side_idx[0]   = a_idx;
  assign side_idx[1]   = b_idx;
  assign side_wdata[0] = a_wdata;
  assign side_wdata[1] = b_wdata;

  for (genvar d = 0; d < 2; d++) begin : g_lane
    // lane d is sent by side d and received by side 1-d
    op_t s_op, r_op;
    assign s_op = (side_sel[d]   == (d == 1)) ? side_op[d]   : OP_NOP;
    assign r_op = (side_sel[1-d] == (d == 1)) ? side_op[1-d] : OP_NOP;

    mbox_lane #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_lane (
      .clk, .rst_n,
      .snd_op(s_op), .snd_idx(side_idx[d]), .snd_data(side_wdata[d]),
      .rcv_op(r_op), .rcv_idx(side_idx[1-d]),
      .flag(lane_flag[d]), .rd_data(lane_rdata[d]), .rd_valid(lane_rvld[d]),
      .snd_bad(lane_sbad[d]), .rcv_bad(lane_rbad[d])
    );
  end

  for (genvar s = 0; s < 2; s++) begin : g_err
    always_ff @(posedge clk) begin
      if (!rst_n) err_q[s] <= 1'b0;
      else        err_q[s] <= err_q[s] | lane_sbad[s] | lane_rbad[1-s];
    end
  end

  assign a_rdata  = lane_rdata[1];
  assign a_rvalid = lane_rvld[1];
  assign b_rdata  = lane_rdata[0];
  assign b_rvalid = lane_rvld[0];
  assign a_err    = err_q[0];
  assign b_err    = err_q[1];
  assign up_flag  = lane_flag[0];
  assign dn_flag  = lane_flag[1];

  // R11
  a_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_err |=> a_err);
  // R11
  b_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_err |=> b_err);
endmodule

// File: tb/duplex_mailbox_test.sv
module duplex_mailbox_test;
  localparam int W = 64;
  localparam int N = 4;
  localparam logic [2:0] NOP = 3'd0, OPEN = 3'd1, PUT = 3'd2, SEAL = 3'd3,
                         GET = 3'd4, DONE = 3'd5, FREE = 3'd6, RSVD = 3'd7;
  localparam logic UP = 1'b0, DN = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] a_op = NOP, b_op = NOP;
  logic a_sel = 1'b0, b_sel = 1'b0;
  logic [1:0] a_idx = '0, b_idx = '0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic a_rvalid, b_rvalid, a_err, b_err;
  logic [1:0] up_flag, dn_flag;

  int vectors = 0;
  int fails = 0;
  logic [W-1:0] msg_up [N];
  logic [W-1:0] msg_dn [N];

  always #10 clk = ~clk;

  duplex_mailbox #(.WORD_W(W), .NUM_WORDS(N)) uut (
    .clk, .rst_n,
    .a_op, .a_sel, .a_idx, .a_wdata, .a_rdata, .a_rvalid, .a_err,
    .b_op, .b_sel, .b_idx, .b_wdata, .b_rdata, .b_rvalid, .b_err,
    .up_flag, .dn_flag
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    a_op = NOP;
    b_op = NOP;
  endtask

  task automatic set_a(input logic [2:0] op, input logic sel, input int idx, input logic [W-1:0] d);
    a_op = op; a_sel = sel; a_idx = 2'(idx); a_wdata = d;
  endtask

  task automatic set_b(input logic [2:0] op, input logic sel, input int idx, input logic [W-1:0] d);
    b_op = op; b_sel = sel; b_idx = 2'(idx); b_wdata = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic fill_msgs();
    for (int i = 0; i < N; i++) begin
      msg_up[i] = {$urandom, $urandom};
      msg_dn[i] = {$urandom, $urandom};
    end
  endtask

  // A sends msg_up on the upstream mailbox, returns commands used
  task automatic send_up(output int cycles);
    cycles = 0;
    set_a(OPEN, UP, 0, '0); step(); cycles++;
    for (int i = 0; i < N; i++) begin
      set_a(PUT, UP, i, msg_up[i]); step(); cycles++;
    end
    set_a(SEAL, UP, 0, '0); step(); cycles++;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 up_flag", 64'(up_flag), 64'd0);
    chk("R1 dn_flag", 64'(dn_flag), 64'd0);
    chk("R1 errors", 64'({a_err, b_err}), 64'd0);
    chk("R1 rvalid", 64'({a_rvalid, b_rvalid}), 64'd0);
    set_a(OPEN, UP, 0, '0); step();
    chk("R1 pre-reset filling", 64'(up_flag), 64'd1);
    do_reset();
    chk("R1 reset mid-message", 64'(up_flag), 64'd0);
  endtask

  task automatic t_upstream();
    int n;
    int rc;
    do_reset();
    fill_msgs();
    set_a(OPEN, UP, 0, '0); step();
    chk("R2 open from idle", 64'(up_flag), 64'd1);
    for (int i = 0; i < N; i++) begin
      set_a(PUT, UP, i, msg_up[i]); step();
    end
    chk("R3 put keeps filling", 64'(up_flag), 64'd1);
    set_a(SEAL, UP, 0, '0); step();
    chk("R4 seal to full", 64'(up_flag), 64'd2);
    rc = 0;
    for (int i = N - 1; i >= 0; i--) begin
      set_b(GET, UP, i, '0); step(); rc++;
      chk("R5 rvalid", 64'(b_rvalid), 64'd1);
      chk("R5 rdata", b_rdata, msg_up[i]);
    end
    set_b(DONE, UP, 0, '0); step(); rc++;
    chk("R5 rvalid drops", 64'(b_rvalid), 64'd0);
    chk("R6 done to taken", 64'(up_flag), 64'd3);
    chk("R6 receive commands", 64'(rc), 64'd5);
    fill_msgs();
    send_up(n);
    chk("R4 send commands", 64'(n), 64'd6);
    chk("R2 open from taken then full", 64'(up_flag), 64'd2);
    set_b(GET, UP, 2, '0); step();
    chk("R3 second message word", b_rdata, msg_up[2]);
    set_b(DONE, UP, 0, '0); step();
    set_b(FREE, UP, 0, '0); step();
    chk("R6 free to idle", 64'(up_flag), 64'd0);
    // open and free together on a taken mailbox
    send_up(n);
    set_b(DONE, UP, 0, '0); step();
    set_a(OPEN, UP, 0, '0); set_b(FREE, UP, 0, '0); step();
    chk("R6 open beats free", 64'(up_flag), 64'd1);
    chk("R6 no errors", 64'({a_err, b_err}), 64'd0);
  endtask

  task automatic t_duplex();
    do_reset();
    for (int r = 0; r < 3; r++) begin
      fill_msgs();
      set_a(OPEN, UP, 0, '0); set_b(OPEN, DN, 0, '0); step();
      for (int i = 0; i < N; i++) begin
        set_a(PUT, UP, i, msg_up[i]); set_b(PUT, DN, i, msg_dn[i]); step();
      end
      set_a(SEAL, UP, 0, '0); set_b(SEAL, DN, 0, '0); step();
      chk("R10 both full", 64'({up_flag, dn_flag}), 64'h0a);
      for (int i = 0; i < N; i++) begin
        set_a(GET, DN, i, '0); set_b(GET, UP, 3 - i, '0); step();
        chk("R10 A reads downstream", a_rdata, msg_dn[i]);
        chk("R10 B reads upstream", b_rdata, msg_up[3 - i]);
      end
      set_a(DONE, DN, 0, '0); set_b(DONE, UP, 0, '0); step();
      chk("R10 both taken", 64'({up_flag, dn_flag}), 64'h0f);
      set_a(FREE, DN, 0, '0); step();
      chk("R10 only downstream freed", 64'({up_flag, dn_flag}), 64'h0c);
      set_b(FREE, UP, 0, '0); step();
    end
    chk("R10 no errors", 64'({a_err, b_err}), 64'd0);
  endtask

  task automatic t_wrong_state();
    int n;
    logic [W-1:0] keep;
    do_reset();
    fill_msgs();
    send_up(n);
    keep = msg_up[2];
    set_b(DONE, UP, 0, '0); step();
    set_b(FREE, UP, 0, '0); step();
    set_a(PUT, UP, 2, ~keep); step();
    chk("R7 put while idle flags A", 64'(a_err), 64'd1);
    chk("R7 put while idle keeps status", 64'(up_flag), 64'd0);
    chk("R7 B unaffected", 64'(b_err), 64'd0);
    set_b(GET, UP, 0, '0); step();
    chk("R7 get while idle flags B", 64'(b_err), 64'd1);
    chk("R7 get while idle no rvalid", 64'(b_rvalid), 64'd0);
    set_a(OPEN, UP, 0, '0); step();
    for (int i = 0; i < N; i++) begin
      if (i != 2) begin
        set_a(PUT, UP, i, ~msg_up[i]); step();
      end
    end
    set_b(DONE, UP, 0, '0); step();
    chk("R7 done while filling keeps status", 64'(up_flag), 64'd1);
    set_a(SEAL, UP, 0, '0); step();
    set_a(SEAL, UP, 0, '0); set_b(FREE, UP, 0, '0); step();
    chk("R7 seal/free while full keeps status", 64'(up_flag), 64'd2);
    set_b(GET, UP, 2, '0); step();
    chk("R7 dropped put left word", b_rdata, keep);
    set_b(GET, UP, 1, '0); step();
    chk("R3 legal put stored", b_rdata, ~msg_up[1]);
  endtask

  task automatic t_wrong_role();
    do_reset();
    fill_msgs();
    set_b(OPEN, DN, 0, '0); step();
    for (int i = 0; i < N; i++) begin
      set_b(PUT, DN, i, msg_dn[i]); step();
    end
    set_a(PUT, DN, 0, ~msg_dn[0]); step();
    chk("R8 A put on downstream flags A", 64'(a_err), 64'd1);
    chk("R8 B not blamed", 64'(b_err), 64'd0);
    set_b(SEAL, DN, 0, '0); step();
    set_a(GET, DN, 0, '0); step();
    chk("R8 rejected put left word", a_rdata, msg_dn[0]);
    set_b(OPEN, UP, 0, '0); step();
    chk("R8 B open on upstream flags B", 64'(b_err), 64'd1);
    chk("R8 upstream stays idle", 64'(up_flag), 64'd0);
    set_b(GET, DN, 1, '0); step();
    chk("R8 sender get gives no rvalid", 64'(b_rvalid), 64'd0);
    chk("R8 downstream stays full", 64'(dn_flag), 64'd2);
  endtask

  task automatic t_reserved();
    do_reset();
    set_a(RSVD, UP, 0, '0); step();
    chk("R9 reserved flags A", 64'(a_err), 64'd1);
    chk("R9 reserved keeps status", 64'({up_flag, dn_flag}), 64'd0);
    chk("R11 other side clean", 64'(b_err), 64'd0);
    for (int i = 0; i < 20; i++) step();
    chk("R11 error sticky", 64'(a_err), 64'd1);
    chk("R9 nop harmless to B", 64'(b_err), 64'd0);
    set_b(RSVD, DN, 0, '0); step();
    chk("R9 reserved flags B", 64'(b_err), 64'd1);
  endtask

  initial begin
    t_reset();
    t_upstream();
    t_duplex();
    t_wrong_state();
    t_wrong_role();
    t_reserved();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule